// File: doc/BRIEF.md
# Nibble-Bus Program ROM with Output Port

This block is a read-only store of 256 bytes that talks to a processor over one shared 4-bit bus. A `sync` pulse starts an instruction cycle of eight phases. Three nibbles arrive on the bus in the first three phases: the low address nibble, the middle address nibble and a chip-select nibble. The chip-select nibble is compared with the instance's fixed identity. The `cmd` line must also be high for the chip to count as selected. A selected chip then returns the addressed byte on the next two phases, upper nibble first. The contents come from a parameter, so every instance can carry its own image.

The same block also serves a 4-bit port. A port-select phase records whether this chip is the current port owner. Later cycles can carry a write-port or read-port code, and the owner then moves a nibble between the bus and the four port pins. A parameter fixes each pin as an output or an input, and a second parameter can invert it. The output register has its own asynchronous clear. A low `rst_n` returns every flop to its idle state.

Phase names used below: A1, A2, A3 (address), M1, M2 (memory), X1, X2, X3 (execute). X3 is also the idle phase.

Top module: `nibble_rom_port`

## Requirements
- R1: When `sync` is high at a rising edge, the next phase is A1 from any phase. Without `sync`, the phases advance one per clock through A1, A2, A3, M1, M2, X1, X2, X3, and the block then stays in X3 until the next `sync`.
- R2: The nibble on `data_i` in A1 is latched as address bits 3:0, and the nibble in A2 as address bits 7:4. Byte n of the image sits at `ROM_IMAGE[8n+7:8n]`.
- R3: The chip is selected for the cycle only if `cmd` is high in A3 and `data_i` in A3 equals `CHIP_ID`.
- R4: A selected chip drives bits 7:4 of the addressed byte in M1 and bits 3:0 in M2, with `data_oe` high.
- R5: `data_oe` is low and `data_o` is zero in every phase where the block does not drive, and in M1 and M2 of an unselected cycle.
- R6: In X2 with `cmd` high and no pending port operation, the chip becomes port owner if `data_i` equals `CHIP_ID`, and stops being owner otherwise. After reset it is not the owner.
- R7: A write-port code 4'b0010 on `data_i` in M2 with `cmd` high, at an owning chip, loads the output-configured bits of the X2 nibble into the port register. The result is visible on `io_out` from X3 on, XOR `PORT_INV_MASK`.
- R8: A read-port code 4'b1010 in M2 with `cmd` high, at an owning chip, drives the bus in X2 with `data_oe` high. Each input-configured bit carries `io_in` XOR `PORT_INV_MASK`, and each output-configured bit reads 0.
- R9: A port code at a chip that is not the owner, or with `cmd` low in M2, has no effect: the bus is not driven in X2 and `io_out` does not change.
- R10: `clr` high clears the port register at once, without a clock edge, so `io_out` becomes `PORT_INV_MASK & PORT_OUT_MASK`.
- R11: `rst_n` low asynchronously clears the phase (to idle X3), the ownership, the selection and the port register.
- R12: An `io_out` bit whose pin is configured as an input (a 0 in `PORT_OUT_MASK`) is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Asynchronous clear of the port register, active high |
| sync | input | 1 | Instruction cycle start marker |
| cmd | input | 1 | Command line qualifying selection and port operations |
| data_i | input | 4 | Bus value as seen by the block |
| data_o | output | 4 | Value the block drives onto the bus |
| data_oe | output | 1 | Bus drive enable (tri-state control) |
| io_in | input | 4 | Port pins sampled as inputs |
| io_out | output | 4 | Port pins driven as outputs |

## Verification
The hardest condition to reach is a port operation that depends on ownership. Ownership is set by a port select in an earlier instruction cycle, so reaching it needs two cycles in order: a select that names this chip, then a write or read code in M2 with `cmd` high. The random stimulus biases the chip-select, M2 and X2 nibbles toward the chip identity and the two port codes, so owned, disowned and stale-owner sequences all occur. Directed sequences add a `sync` restart in the middle of a cycle, an idle hold, a clear between edges and a reset after a write.

// File: rtl/nrp_pkg.sv
package nrp_pkg;

    localparam int NIB_W   = 4;
    localparam int WORD_W  = 2 * NIB_W;
    localparam int WORDS   = 1 << (2 * NIB_W);
    localparam int IMAGE_W = WORDS * WORD_W;

    typedef logic [NIB_W-1:0] nib_t;

    // Phase order is the bus protocol; X3 doubles as idle.
    typedef enum logic [2:0] {
        PH_A1, PH_A2, PH_A3, PH_M1, PH_M2, PH_X1, PH_X2, PH_X3
    } phase_e;

    localparam nib_t OP_PORT_WR = 4'b0010;
    localparam nib_t OP_PORT_RD = 4'b1010;

    typedef struct packed {
        nib_t addr_lo;
        nib_t addr_mid;
        logic rom_sel;
    } addr_st_t;

    typedef struct packed {
        logic owner;
        logic wr_pend;
        logic rd_pend;
    } port_st_t;

    function automatic logic [IMAGE_W-1:0] default_image();
        logic [IMAGE_W-1:0] img;
        img = '0;
        for (int i = 0; i < WORDS; i++) begin
            img[i*WORD_W +: WORD_W] = WORD_W'((i * 29 + 7) ^ (i >> 3));
        end
        return img;
    endfunction

endpackage

// File: rtl/nrp_phase_seq.sv
module nrp_phase_seq
    import nrp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sync,
    output phase_e phase_o
);

    phase_e phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (sync) begin
            phase_d = PH_A1;
        end else if (phase_q != PH_X3) begin
            phase_d = phase_e'(phase_q + 3'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_X3;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/nrp_rom_lookup.sv
module nrp_rom_lookup #(
    parameter int WORDS  = 256,
    parameter int WORD_W = 8,
    parameter logic [WORDS*WORD_W-1:0] IMAGE = '0,
    localparam int AW = $clog2(WORDS)
) (
    input  logic [AW-1:0]     addr,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign mem[g] = IMAGE[g*WORD_W +: WORD_W];
    end

    assign word = mem[addr];

endmodule

// File: rtl/nrp_io_port.sv
module nrp_io_port
    import nrp_pkg::*;
#(
    parameter nib_t CHIP_ID  = 4'd0,
    parameter nib_t OUT_MASK = 4'b1111,
    parameter nib_t INV_MASK = 4'b0000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  logic   sync,
    input  logic   cmd,
    input  phase_e phase,
    input  nib_t   data_i,
    input  nib_t   io_in,
    output logic   rd_drive,
    output nib_t   rd_data,
    output nib_t   io_out,
    output nib_t   out_reg
);

    port_st_t st_d, st_q;
    nib_t     out_d, out_q;

    always_comb begin
        st_d  = st_q;
        out_d = out_q;
        if (sync) begin
            st_d.wr_pend = 1'b0;
            st_d.rd_pend = 1'b0;
        end else begin
            unique case (phase)
                PH_M2: begin
                    st_d.wr_pend = cmd && st_q.owner && (data_i == OP_PORT_WR);
                    st_d.rd_pend = cmd && st_q.owner && (data_i == OP_PORT_RD);
                end
                PH_X2: begin
                    if (st_q.wr_pend) begin
                        out_d = data_i & OUT_MASK;
                    end else if (cmd && !st_q.rd_pend) begin
                        st_d.owner = (data_i == CHIP_ID);
                    end
                end
                PH_X3: begin
                    st_d.wr_pend = 1'b0;
                    st_d.rd_pend = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Port register has its own asynchronous clear besides reset.
    always_ff @(posedge clk or negedge rst_n or posedge clr) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (clr) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_drive = (phase == PH_X2) && st_q.rd_pend;
    assign out_reg  = out_q;

    for (genvar g = 0; g < NIB_W; g++) begin : g_pin
        if (OUT_MASK[g]) begin : g_out
            assign io_out[g]  = out_q[g] ^ INV_MASK[g];
            assign rd_data[g] = 1'b0;
        end else begin : g_in
            assign io_out[g]  = 1'b0;
            assign rd_data[g] = io_in[g] ^ INV_MASK[g];
        end
    end

endmodule

// File: rtl/nibble_rom_port.sv
module nibble_rom_port
    import nrp_pkg::*;
#(
    parameter nib_t                CHIP_ID       = 4'd0,
    parameter logic [IMAGE_W-1:0]  ROM_IMAGE     = nrp_pkg::default_image(),
    parameter nib_t                PORT_OUT_MASK = 4'b1111,
    parameter nib_t                PORT_INV_MASK = 4'b0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sync,
    input  logic             cmd,
    input  logic [NIB_W-1:0] data_i,
    output logic [NIB_W-1:0] data_o,
    output logic             data_oe,
    input  logic [NIB_W-1:0] io_in,
    output logic [NIB_W-1:0] io_out
);

    localparam int AW = $clog2(WORDS);

    phase_e            phase_q;
    addr_st_t          a_d, a_q;
    logic [WORD_W-1:0] rom_word;
    logic              rd_drive;
    nib_t              rd_data;
    nib_t              port_out_q;

    nrp_phase_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync    (sync),
        .phase_o (phase_q)
    );

    nrp_rom_lookup #(
        .WORDS  (WORDS),
        .WORD_W (WORD_W),
        .IMAGE  (ROM_IMAGE)
    ) u_rom (
        .addr (AW'({a_q.addr_mid, a_q.addr_lo})),
        .word (rom_word)
    );

    nrp_io_port #(
        .CHIP_ID  (CHIP_ID),
        .OUT_MASK (PORT_OUT_MASK),
        .INV_MASK (PORT_INV_MASK)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .sync     (sync),
        .cmd      (cmd),
        .phase    (phase_q),
        .data_i   (data_i),
        .io_in    (io_in),
        .rd_drive (rd_drive),
        .rd_data  (rd_data),
        .io_out   (io_out),
        .out_reg  (port_out_q)
    );

    always_comb begin
        a_d = a_q;
        if (sync) begin
            a_d.rom_sel = 1'b0;
        end else begin
            unique case (phase_q)
                PH_A1:   a_d.addr_lo  = data_i;
                PH_A2:   a_d.addr_mid = data_i;
                PH_A3:   a_d.rom_sel  = cmd && (data_i == CHIP_ID);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    // Bus drive: one source per phase, released everywhere else.
    always_comb begin
        data_oe = 1'b0;
        data_o  = '0;
        unique case (phase_q)
            PH_M1: if (a_q.rom_sel) begin
                data_oe = 1'b1;
                data_o  = rom_word[WORD_W-1 -: NIB_W];
            end
            PH_M2: if (a_q.rom_sel) begin
                data_oe = 1'b1;
                data_o  = rom_word[NIB_W-1:0];
            end
            PH_X2: if (rd_drive) begin
                data_oe = 1'b1;
                data_o  = rd_data;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nrp_checker.sv
module nrp_checker
    import nrp_pkg::*;
#(
    parameter nib_t OUT_MASK = 4'b1111,
    parameter nib_t INV_MASK = 4'b0000
) (
    input logic   clk,
    input logic   rst_n,
    input logic   clr,
    input logic   sync,
    input logic   data_oe,
    input nib_t   io_out,
    input phase_e phase,
    input nib_t   out_reg
);

    p_sync_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (phase == PH_A1));

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_X3 && !sync) |=> (phase == PH_X3));

    p_bus_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (phase == PH_M1 || phase == PH_M2 || phase == PH_X2));

    p_port_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !$past(clr) && $past(phase) != PH_X2) |-> $stable(out_reg));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (io_out == (INV_MASK & OUT_MASK)));

    p_input_pins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_out & ~OUT_MASK) == '0));

endmodule

bind nibble_rom_port nrp_checker #(
    .OUT_MASK (PORT_OUT_MASK),
    .INV_MASK (PORT_INV_MASK)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .sync    (sync),
    .data_oe (data_oe),
    .io_out  (io_out),
    .phase   (phase_q),
    .out_reg (port_out_q)
);

// File: tb/nibble_rom_port_tb.sv
module nibble_rom_port_tb;

    localparam int   CLK_PERIOD = 10;
    localparam logic [3:0] ID   = 4'hA;
    localparam logic [3:0] OUTM = 4'b1011;
    localparam logic [3:0] INVM = 4'b0101;

    function automatic logic [2047:0] tb_image();
        logic [2047:0] img;
        img = '0;
        for (int i = 0; i < 256; i++) img[i*8 +: 8] = 8'((i * 73 + 29) ^ (i >> 2));
        return img;
    endfunction

    localparam logic [2047:0] IMG = tb_image();

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, sync = 1'b0, cmd = 1'b0;
    logic [3:0] data_i = '0, io_in = '0;
    logic [3:0] data_o, io_out;
    logic data_oe;

    int checks = 0, errors = 0;
    logic owner_m = 1'b0;
    logic [3:0] out_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nibble_rom_port #(
        .CHIP_ID (ID), .ROM_IMAGE (IMG),
        .PORT_OUT_MASK (OUTM), .PORT_INV_MASK (INVM)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .clr (clr), .sync (sync), .cmd (cmd),
        .data_i (data_i), .data_o (data_o), .data_oe (data_oe),
        .io_in (io_in), .io_out (io_out)
    );

    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        return IMG[a*8 +: 8];
    endfunction

    function automatic logic [3:0] exp_pins(input logic [3:0] r);
        return (r ^ INVM) & OUTM;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step(input logic s, input logic [3:0] d, input logic c);
        @(negedge clk);
        sync = s; data_i = d; cmd = c;
        #1;
    endtask

    // Expects the previous edge to have seen sync.
    task automatic run_cycle(input logic [3:0] lo, mid, cs, input logic c3,
                             input logic [3:0] m2, input logic c2,
                             input logic [3:0] x2, input logic cx,
                             input logic [3:0] pin, input logic nxt);
        logic sel, wr, rd;
        logic [7:0] b;
        sel = (cs == ID) && c3;
        b   = exp_byte({mid, lo});
        step(1'b0, lo, 1'b0);   chk("R5 A1 idle bus", {7'd0, data_oe}, 8'd0);
        step(1'b0, mid, 1'b0);  chk("R5 A2 idle bus", {7'd0, data_oe}, 8'd0);
        step(1'b0, cs, c3);     chk("R5 A3 idle bus", {7'd0, data_oe}, 8'd0);
        step(1'b0, 4'h0, 1'b0);
        chk("R3 M1 select", {7'd0, data_oe}, {7'd0, sel});
        chk("R4 R2 M1 high nibble", {4'd0, data_o}, sel ? {4'd0, b[7:4]} : 8'd0);
        step(1'b0, m2, c2);
        chk("R3 M2 select", {7'd0, data_oe}, {7'd0, sel});
        chk("R4 R2 M2 low nibble", {4'd0, data_o}, sel ? {4'd0, b[3:0]} : 8'd0);
        wr = c2 && owner_m && (m2 == 4'b0010);
        rd = c2 && owner_m && (m2 == 4'b1010);
        step(1'b0, 4'h0, 1'b0); chk("R5 X1 idle bus", {7'd0, data_oe}, 8'd0);
        io_in = pin;
        step(1'b0, x2, cx);
        chk("R8 R9 X2 drive", {7'd0, data_oe}, {7'd0, rd});
        chk("R8 X2 read data", {4'd0, data_o}, rd ? {4'd0, (pin ^ INVM) & ~OUTM} : 8'd0);
        if (wr) out_m = x2 & OUTM;
        else if (cx && !rd) owner_m = (x2 == ID);
        step(nxt, 4'h0, 1'b0);
        chk("R7 R9 R12 port pins", {4'd0, io_out}, {4'd0, exp_pins(out_m)});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R11 reset pins", {4'd0, io_out}, {4'd0, exp_pins(4'd0)});
        chk("R11 reset bus", {7'd0, data_oe}, 8'd0);
        @(negedge clk); rst_n = 1'b1;

        step(1'b1, 4'h0, 1'b0);
        // R6: not owner after reset, so a write is ignored
        run_cycle(4'h0, 4'h0, ID, 1, 4'b0010, 1, 4'hF, 0, 4'h0, 1);
        // R6: become owner
        run_cycle(4'h3, 4'h1, ID, 1, 4'h0, 0, ID, 1, 4'h0, 1);
        // R7 write
        run_cycle(4'hF, 4'hF, ID, 1, 4'b0010, 1, 4'hF, 0, 4'h0, 1);
        // R8 read
        run_cycle(4'h5, 4'h9, ID, 1, 4'b1010, 1, 4'h0, 0, 4'b1110, 1);
        // R3: wrong chip, and right chip without cmd
        run_cycle(4'h1, 4'h2, ID ^ 4'h1, 1, 4'h0, 0, 4'h0, 0, 4'h0, 1);
        run_cycle(4'h1, 4'h2, ID, 0, 4'h0, 0, 4'h0, 0, 4'h0, 1);
        // R9: write with cmd low in M2
        run_cycle(4'h0, 4'h8, ID, 1, 4'b0010, 0, 4'h0, 0, 4'h0, 1);
        // R6 R9: select another chip, then write is ignored
        run_cycle(4'h4, 4'h4, ID, 1, 4'h0, 0, ID ^ 4'h3, 1, 4'h0, 1);
        run_cycle(4'h4, 4'h4, ID, 1, 4'b0010, 1, 4'h0, 0, 4'h0, 1);
        run_cycle(4'h6, 4'h6, ID, 1, 4'h0, 0, ID, 1, 4'h0, 1);
        run_cycle(4'h6, 4'h6, ID, 1, 4'b0010, 1, 4'h9, 0, 4'h0, 0);

        // R1: idle hold, then R10 clear between edges
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 4'hF, 1'b1);
            chk("R1 idle hold no drive", {7'd0, data_oe}, 8'd0);
        end
        #2 clr = 1'b1; #1;
        out_m = 4'd0;
        chk("R10 async clear", {4'd0, io_out}, {4'd0, exp_pins(4'd0)});
        @(negedge clk); clr = 1'b0;

        // R1: restart in the middle of a cycle
        step(1'b1, 4'h0, 1'b0);
        step(1'b0, 4'h7, 1'b0);
        step(1'b1, 4'h7, 1'b0);
        run_cycle(4'hF, 4'hF, ID, 1, 4'b0010, 1, 4'hB, 0, 4'h0, 1);
        chk("R1 R7 restart write", {4'd0, io_out}, {4'd0, exp_pins(4'hB & OUTM)});

        for (int n = 0; n < 400; n++) begin
            logic [3:0] cs, m2, x2;
            int r;
            r  = int'($urandom_range(0, 3));
            cs = (r == 0) ? 4'($urandom) : ID;
            r  = int'($urandom_range(0, 3));
            m2 = (r == 0) ? 4'b0010 : (r == 1) ? 4'b1010 : 4'($urandom);
            r  = int'($urandom_range(0, 2));
            x2 = (r == 0) ? ID : 4'($urandom);
            run_cycle(4'($urandom), 4'($urandom), cs, 1'($urandom_range(0, 5) != 0),
                      m2, 1'($urandom), x2, 1'($urandom), 4'($urandom), 1'b1);
        end

        // R11: reset after a write clears pins and ownership
        run_cycle(4'h2, 4'h2, ID, 1, 4'h0, 0, ID, 1, 4'h0, 1);
        run_cycle(4'h2, 4'h2, ID, 1, 4'b0010, 1, 4'hF, 0, 4'h0, 0);
        #2 rst_n = 1'b0; #1;
        owner_m = 1'b0; out_m = 4'd0;
        chk("R11 async reset pins", {4'd0, io_out}, {4'd0, exp_pins(4'd0)});
        @(negedge clk); rst_n = 1'b1;
        step(1'b1, 4'h0, 1'b0);
        run_cycle(4'h2, 4'h2, ID, 1, 4'b0010, 1, 4'hF, 0, 4'h0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule